// File: doc/BRIEF.md
# SPI Register Access Slave with Masked Update

This block sits between an external SPI host and a byte-wide register file inside a chip. The host lowers chip select, sends an instruction byte and, depending on the instruction, an address, a mask and data bytes. The block turns these into read strobes and write strobes on a simple register-file port. Read data goes back on the serial output.

Besides plain burst read and burst write, it offers four more commands. A masked update changes only selected bits of one register. A short read instruction carries its own start address for one of two receive buffers. A status instruction returns a packed byte describing the received frames. A reset instruction produces a one-cycle pulse.

The serial pins are oversampled by the system clock. Both clock-idle-low (mode 0,0) and clock-idle-high (mode 1,1) hosts are served by the same logic.

The controller is a state machine with these states:

- ST_IDLE: chip select is high.
- ST_CMD: the instruction byte is being received.
- ST_ADDR: the address byte is being received.
- ST_MASK: the mask byte is being received.
- ST_WDATA: write burst.
- ST_MDATA: masked data byte.
- ST_RDATA: read burst output.
- ST_STAT: status output.
- ST_SKIP: the rest of the frame is ignored.

Transitions:

- Any state goes to ST_IDLE when chip select rises.
- ST_IDLE goes to ST_CMD on the cycle after chip select falls.
- ST_CMD goes to ST_ADDR after a read, write or masked-update instruction.
- ST_CMD goes to ST_RDATA after a receive-buffer read instruction.
- ST_CMD goes to ST_STAT after a status instruction.
- ST_CMD goes to ST_SKIP after a reset instruction or an unknown byte.
- ST_ADDR goes to ST_RDATA, ST_WDATA or ST_MASK, according to the command.
- ST_MASK goes to ST_MDATA.
- ST_MDATA goes to ST_SKIP.
- ST_WDATA, ST_RDATA and ST_STAT stay in place until chip select rises.

Top module: `spi_regacc_top`

## Requirements
- R1: After reset, spi_miso_oe, rf_we, rf_re, soft_rst and rxb_flag_clr are all low.
- R2: MOSI is sampled on rising SCK and MISO changes only after falling SCK. Transfers work with SCK idling low (mode 0,0) and with SCK idling high (mode 1,1). All bytes go MSB first.
- R3: Instruction 0x02, then an address byte, then N data bytes, writes the data to consecutive addresses starting at the given address.
- R4: Instruction 0x03, then an address byte, returns the register at that address on MISO. The address increments after every output byte for as long as chip select stays low.
- R5: Instruction 0x05, then address, mask and data bytes, writes (old AND NOT mask) OR (data AND mask) to the addressed register. A mask of 0xFF therefore acts as a full write.
- R6: Instruction 1001_0BD0 starts a read burst without an address byte. Bit 2 (B) selects the buffer and bit 1 (D) selects header or data. The start address is 0x61 for B=0,D=0; 0x66 for B=0,D=1; 0x71 for B=1,D=0; and 0x76 for B=1,D=1.
- R7: Instruction 0xB0 returns a status byte, repeated for every further byte clocked. Bit 7 is rxb_full[1], bit 6 is rxb_full[0], bit 4 is rxb_ext and bit 3 is rxb_rtr. All other bits are 0.
- R8: spi_miso_oe is high only during the output phase of a read, receive-buffer read or status command. It is low during writes and while chip select is high.
- R9: Raising chip select in the middle of a byte aborts the command, and that partial byte causes no write. The next falling edge of chip select starts a fresh instruction.
- R10: When chip select rises after a receive-buffer read, rxb_flag_clr pulses for one cycle on the bit of the selected buffer only.
- R11: Instruction 0xC0 pulses soft_rst for exactly one cycle and causes no register access.
- R12: An undefined instruction byte and every byte that follows it cause no write and no MISO output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| rf_addr | output | ADDR_W | Register-file address |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 8 | Register-file write data |
| rf_re | output | 1 | Register-file read strobe |
| rf_rdata | input | 8 | Register-file read data for rf_addr, same cycle |
| rxb_full | input | 2 | Receive-buffer full flags |
| rxb_ext | input | 1 | Received frame uses an extended identifier |
| rxb_rtr | input | 1 | Received frame is a remote request |
| rxb_flag_clr | output | 2 | One-cycle clear strobes for the receive flags |
| soft_rst | output | 1 | Software reset pulse |

## Verification
The hardest case to reach from the ports is a chip-select rise in the middle of a byte that follows a valid write address. The bench reaches it with a transfer that sends only four bits of the data byte and then deasserts select. It then proves that the address was untouched, and that a new command decodes cleanly, by reading the same register back.

Both clock polarities are also exercised on writes, reads and status. This shows that the first output bit appears correctly whether or not a falling edge comes before the first rising edge.

// File: rtl/spi_ra_pkg.sv
package spi_ra_pkg;

    typedef enum logic [7:0] {
        OP_RESET  = 8'hC0,
        OP_READ   = 8'h03,
        OP_WRITE  = 8'h02,
        OP_MODIFY = 8'h05,
        OP_RXSTAT = 8'hB0
    } spi_op_e;

    // short receive-buffer read: 1001_0BD0
    localparam logic [7:0] OP_RXBUF_MASK = 8'hF9;
    localparam logic [7:0] OP_RXBUF_VAL  = 8'h90;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_MASK,
        ST_WDATA,
        ST_MDATA,
        ST_RDATA,
        ST_STAT,
        ST_SKIP
    } ctrl_state_e;

    typedef enum logic [1:0] {
        ACC_RD,
        ACC_WR,
        ACC_MOD
    } acc_e;

endpackage

// File: rtl/spi_ra_sync.sv
module spi_ra_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic active,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sck_p, cs_p, mosi_p;
    logic         sck_d;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_p  <= '0;
                    cs_p   <= '1;
                    mosi_p <= '0;
                end else begin
                    sck_p  <= sck;
                    cs_p   <= cs_n;
                    mosi_p <= mosi;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sck_p  <= '0;
                    cs_p   <= '1;
                    mosi_p <= '0;
                end else begin
                    sck_p  <= {sck_p[TOP-1:0], sck};
                    cs_p   <= {cs_p[TOP-1:0], cs_n};
                    mosi_p <= {mosi_p[TOP-1:0], mosi};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_p[TOP];
    end

    assign sck_rise = sck_p[TOP] & ~sck_d;
    assign sck_fall = ~sck_p[TOP] & sck_d;
    assign active   = ~cs_p[TOP];
    assign mosi_s   = mosi_p[TOP];

endmodule

// File: rtl/spi_ra_shifter.sv
module spi_ra_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              miso_bit
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh;
    logic              so_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
            so_q  <= 1'b0;
        end else if (!active) begin
            cnt   <= '0;
            tx_sh <= '0;
            so_q  <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx_sh <= rx_byte;
                cnt   <= (cnt == CNT_W'(BYTE_W - 1)) ? '0 : cnt + 1'b1;
            end
            if (load) begin
                tx_sh <= load_byte;
            end else if (sck_fall) begin
                so_q  <= tx_sh[BYTE_W-1];
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign rx_byte   = {rx_sh[BYTE_W-2:0], mosi_s};
    assign byte_done = active && sck_rise && (cnt == CNT_W'(BYTE_W - 1));
    assign miso_bit  = so_q;

    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt == '0)); // R9

    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && (so_q != $past(so_q))) |-> $past(sck_fall)); // R2

endmodule

// File: rtl/spi_ra_ctrl.sv
module spi_ra_ctrl
    import spi_ra_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] RXB0_BASE = 8'h60,
    parameter logic [ADDR_W-1:0] RXB1_BASE = 8'h70,
    parameter int              HDR_OFS   = 1,
    parameter int              DATA_OFS  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic [7:0]        rf_rdata,
    input  logic [1:0]        rxb_full,
    input  logic              rxb_ext,
    input  logic              rxb_rtr,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [7:0]        rf_wdata,
    output logic              rf_re,
    output logic              load,
    output logic [7:0]        load_byte,
    output logic              miso_oe,
    output logic [1:0]        rxb_flag_clr,
    output logic              soft_rst
);
    ctrl_state_e       state_q, state_d;
    acc_e              acc_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        mask_q;
    logic              load_q, sw_rst_q, rxb_used_q, rxb_sel_q;
    logic [1:0]        clr_q;

    logic is_rd, is_wr, is_mod, is_stat, is_rxb, is_rst;
    logic [ADDR_W-1:0] rxb_start;
    logic [7:0]        stat_byte;

    assign is_rd   = (rx_byte == OP_READ);
    assign is_wr   = (rx_byte == OP_WRITE);
    assign is_mod  = (rx_byte == OP_MODIFY);
    assign is_stat = (rx_byte == OP_RXSTAT);
    assign is_rst  = (rx_byte == OP_RESET);
    assign is_rxb  = ((rx_byte & OP_RXBUF_MASK) == OP_RXBUF_VAL);

    assign rxb_start = (rx_byte[2] ? RXB1_BASE : RXB0_BASE)
                     + (rx_byte[1] ? ADDR_W'(DATA_OFS) : ADDR_W'(HDR_OFS));

    assign stat_byte = {rxb_full[1], rxb_full[0], 1'b0, rxb_ext, rxb_rtr, 3'b000};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_CMD;
                ST_CMD: if (byte_done) begin
                    if (is_rd || is_wr || is_mod) state_d = ST_ADDR;
                    else if (is_rxb)              state_d = ST_RDATA;
                    else if (is_stat)             state_d = ST_STAT;
                    else                          state_d = ST_SKIP;
                end
                ST_ADDR: if (byte_done) begin
                    unique case (acc_q)
                        ACC_RD:  state_d = ST_RDATA;
                        ACC_WR:  state_d = ST_WDATA;
                        default: state_d = ST_MASK;
                    endcase
                end
                ST_MASK:  if (byte_done) state_d = ST_MDATA;
                ST_MDATA: if (byte_done) state_d = ST_SKIP;
                ST_WDATA, ST_RDATA, ST_STAT, ST_SKIP: state_d = state_q;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= ACC_RD;
            addr_q     <= '0;
            mask_q     <= '0;
            load_q     <= 1'b0;
            sw_rst_q   <= 1'b0;
            rxb_used_q <= 1'b0;
            rxb_sel_q  <= 1'b0;
            clr_q      <= '0;
        end else begin
            load_q   <= 1'b0;
            sw_rst_q <= 1'b0;
            clr_q    <= '0;
            if (!active) begin
                if (rxb_used_q) begin
                    clr_q[rxb_sel_q] <= 1'b1;
                    rxb_used_q       <= 1'b0;
                end
            end else if (byte_done) begin
                unique case (state_q)
                    ST_CMD: begin
                        if (is_wr)       acc_q <= ACC_WR;
                        else if (is_mod) acc_q <= ACC_MOD;
                        else             acc_q <= ACC_RD;
                        if (is_rst) sw_rst_q <= 1'b1;
                        if (is_rxb) begin
                            addr_q     <= rxb_start;
                            rxb_sel_q  <= rx_byte[2];
                            rxb_used_q <= 1'b1;
                            load_q     <= 1'b1;
                        end
                        if (is_stat) load_q <= 1'b1;
                    end
                    ST_ADDR: begin
                        addr_q <= rx_byte[ADDR_W-1:0];
                        if (acc_q == ACC_RD) load_q <= 1'b1;
                    end
                    ST_MASK:  mask_q <= rx_byte;
                    ST_WDATA: addr_q <= addr_q + 1'b1;
                    ST_RDATA: begin
                        addr_q <= addr_q + 1'b1;
                        load_q <= 1'b1;
                    end
                    ST_STAT:  load_q <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        rf_addr      = addr_q;
        rf_we        = byte_done && ((state_q == ST_WDATA) || (state_q == ST_MDATA));
        rf_wdata     = (state_q == ST_MDATA) ? ((rf_rdata & ~mask_q) | (rx_byte & mask_q))
                                             : rx_byte;
        rf_re        = load_q && (state_q == ST_RDATA);
        load         = load_q;
        load_byte    = (state_q == ST_STAT) ? stat_byte : rf_rdata;
        miso_oe      = active && ((state_q == ST_RDATA) || (state_q == ST_STAT));
        rxb_flag_clr = clr_q;
        soft_rst     = sw_rst_q;
    end

    AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> active); // R9

    AST_OE_NOT_WITH_WE: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !rf_we); // R8

    AST_READ_IN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        rf_re |-> miso_oe); // R4

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rxb_flag_clr)); // R10

    AST_CLR_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (|rxb_flag_clr) |-> !active); // R10

    AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst); // R11

endmodule

// File: rtl/spi_regacc_top.sv
module spi_regacc_top #(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] rf_addr,
    output logic              rf_we,
    output logic [7:0]        rf_wdata,
    output logic              rf_re,
    input  logic [7:0]        rf_rdata,
    input  logic [1:0]        rxb_full,
    input  logic              rxb_ext,
    input  logic              rxb_rtr,
    output logic [1:0]        rxb_flag_clr,
    output logic              soft_rst
);
    localparam int BYTE_W = 8;

    logic sck_rise, sck_fall, active, mosi_s;
    logic byte_done, load;
    logic [BYTE_W-1:0] rx_byte, load_byte;

    spi_ra_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .active   (active),
        .mosi_s   (mosi_s)
    );

    spi_ra_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_s    (mosi_s),
        .load      (load),
        .load_byte (load_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso_bit  (spi_miso)
    );

    spi_ra_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .active       (active),
        .byte_done    (byte_done),
        .rx_byte      (rx_byte),
        .rf_rdata     (rf_rdata),
        .rxb_full     (rxb_full),
        .rxb_ext      (rxb_ext),
        .rxb_rtr      (rxb_rtr),
        .rf_addr      (rf_addr),
        .rf_we        (rf_we),
        .rf_wdata     (rf_wdata),
        .rf_re        (rf_re),
        .load         (load),
        .load_byte    (load_byte),
        .miso_oe      (spi_miso_oe),
        .rxb_flag_clr (rxb_flag_clr),
        .soft_rst     (soft_rst)
    );

endmodule

// File: tb/tb_spi_regacc_top.sv
module tb_spi_regacc_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, rf_we, rf_re, soft_rst;
    logic [7:0] rf_addr, rf_wdata;
    logic [1:0] rxb_full = 2'b00, rxb_flag_clr;
    logic rxb_ext = 1'b0, rxb_rtr = 1'b0;
    logic [7:0] mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_regacc_top dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .rf_addr(rf_addr), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_re(rf_re), .rf_rdata(mem[rf_addr]),
        .rxb_full(rxb_full), .rxb_ext(rxb_ext), .rxb_rtr(rxb_rtr),
        .rxb_flag_clr(rxb_flag_clr), .soft_rst(soft_rst)
    );

    // register file outside the block
    always @(posedge clk) if (rf_we) mem[rf_addr] <= rf_wdata;

    int we_cnt = 0, rst_cnt = 0, clr0_cnt = 0, clr1_cnt = 0;
    always @(posedge clk) begin
        if (rf_we)           we_cnt++;
        if (soft_rst)        rst_cnt++;
        if (rxb_flag_clr[0]) clr0_cnt++;
        if (rxb_flag_clr[1]) clr1_cnt++;
    end

    int total = 0, bad = 0;
    bit cpol = 1'b0, oe_seen = 1'b0, finished = 1'b0;

    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t exp_q[$];
    logic [7:0] got_q[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0 && got_q.size() > 0) begin
            exp_t e;
            logic [7:0] g;
            e = exp_q.pop_front();
            g = got_q.pop_front();
            check(g == e.v, e.tag, g, e.v);
        end
    end

    task automatic waith(); repeat (HALF) @(negedge clk); endtask

    task automatic cs_begin();
        sck = cpol; waith(); cs_n = 1'b0; oe_seen = 1'b0; waith();
    endtask

    task automatic cs_end();
        waith(); cs_n = 1'b1; repeat (4) waith();
    endtask

    task automatic xbit(input logic b, output logic r);
        if (cpol) begin
            sck = 1'b0; mosi = b; waith();
            sck = 1'b1; r = miso; oe_seen |= miso_oe; waith();
        end else begin
            mosi = b; waith();
            sck = 1'b1; r = miso; oe_seen |= miso_oe; waith();
            sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] b, input int nbits, output logic [7:0] r);
        r = '0;
        for (int i = 7; i >= 8 - nbits; i--) begin
            logic x;
            xbit(b[i], x);
            r[i] = x;
        end
    endtask

    task automatic send(input logic [7:0] b);
        logic [7:0] r;
        xbyte(b, 8, r);
    endtask

    task automatic recv_expect(input logic [7:0] v, input string tag);
        logic [7:0] r;
        exp_t e;
        e.v = v; e.tag = tag;
        exp_q.push_back(e);
        xbyte(8'h00, 8, r);
        got_q.push_back(r);
    endtask

    task automatic wr_burst(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1, input int n);
        cs_begin(); send(8'h02); send(a); send(d0);
        if (n > 1) send(d1);
        cs_end();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] r;
        int w0, c0, c1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(!miso_oe && !rf_we && !rf_re && !soft_rst && rxb_flag_clr == 2'b00,
              "R1 reset outputs", {miso_oe, rf_we, rf_re, soft_rst, rxb_flag_clr}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!miso_oe && rxb_flag_clr == 2'b00, "R1 after release", miso_oe, 0);

        // R3 write burst, mode 0,0, plus R8 no output during write
        cpol = 1'b0;
        cs_begin(); send(8'h02); send(8'h10); send(8'hAA); send(8'h55); send(8'hC3);
        check(!oe_seen, "R8 oe during write", oe_seen, 0);
        cs_end();
        check(mem[8'h10] == 8'hAA, "R3 burst byte0", mem[8'h10], 8'hAA);
        check(mem[8'h11] == 8'h55, "R3 burst byte1", mem[8'h11], 8'h55);
        check(mem[8'h12] == 8'hC3, "R3 burst byte2", mem[8'h12], 8'hC3);
        check(!miso_oe, "R8 oe idle", miso_oe, 0);

        // R4 read burst mode 0,0
        cs_begin(); send(8'h03); send(8'h10);
        recv_expect(8'hAA, "R4 read b0"); recv_expect(8'h55, "R4 read b1");
        recv_expect(8'hC3, "R4 read b2");
        cs_end();

        // R2 mode 1,1 write and read
        cpol = 1'b1;
        wr_burst(8'h20, 8'h81, 8'h7E, 2);
        check(mem[8'h20] == 8'h81 && mem[8'h21] == 8'h7E, "R2 mode11 write", mem[8'h20], 8'h81);
        cs_begin(); send(8'h03); send(8'h20);
        recv_expect(8'h81, "R2 mode11 read b0"); recv_expect(8'h7E, "R2 mode11 read b1");
        cs_end();
        cpol = 1'b0;

        // R5 masked update
        wr_burst(8'h2A, 8'hA5, 8'h00, 1);
        cs_begin(); send(8'h05); send(8'h2A); send(8'h0F); send(8'h3C); cs_end();
        check(mem[8'h2A] == 8'hAC, "R5 masked update", mem[8'h2A], 8'hAC);
        cs_begin(); send(8'h05); send(8'h2A); send(8'hFF); send(8'h5A); cs_end();
        check(mem[8'h2A] == 8'h5A, "R5 full mask", mem[8'h2A], 8'h5A);

        // R6 / R10 receive-buffer shortcut
        wr_burst(8'h61, 8'h11, 8'h22, 2);
        wr_burst(8'h66, 8'h33, 8'h44, 2);
        wr_burst(8'h71, 8'h55, 8'h56, 2);
        wr_burst(8'h76, 8'h66, 8'h77, 2);
        c0 = clr0_cnt; c1 = clr1_cnt;
        cs_begin(); send(8'h90);
        recv_expect(8'h11, "R6 sel00 b0"); recv_expect(8'h22, "R6 sel00 b1");
        cs_end();
        check(clr0_cnt == c0 + 1 && clr1_cnt == c1, "R10 clear buf0", clr0_cnt - c0, 1);
        cs_begin(); send(8'h92); recv_expect(8'h33, "R6 sel01"); cs_end();
        cs_begin(); send(8'h94); recv_expect(8'h55, "R6 sel10"); cs_end();
        c0 = clr0_cnt; c1 = clr1_cnt;
        cpol = 1'b1;
        cs_begin(); send(8'h96);
        recv_expect(8'h66, "R6 sel11 b0"); recv_expect(8'h77, "R6 sel11 b1");
        cs_end();
        check(clr1_cnt == c1 + 1 && clr0_cnt == c0, "R10 clear buf1", clr1_cnt - c1, 1);

        // R7 status, mode 1,1 then 0,0
        rxb_full = 2'b10; rxb_ext = 1'b1; rxb_rtr = 1'b0;
        cs_begin(); send(8'hB0);
        recv_expect(8'h90, "R7 status ext data"); recv_expect(8'h90, "R7 status repeat");
        cs_end();
        cpol = 1'b0;
        rxb_full = 2'b01; rxb_ext = 1'b0; rxb_rtr = 1'b1;
        cs_begin(); send(8'hB0); recv_expect(8'h48, "R7 status std remote"); cs_end();

        // R11 reset instruction
        w0 = we_cnt;
        cs_begin(); send(8'hC0); send(8'h02); cs_end();
        check(rst_cnt == 1, "R11 reset pulse count", rst_cnt, 1);
        check(we_cnt == w0, "R11 no write", we_cnt - w0, 0);

        // R12 undefined instruction
        w0 = we_cnt;
        cs_begin(); send(8'hFF); send(8'h02); send(8'h10); send(8'h99);
        check(!oe_seen, "R12 no output", oe_seen, 0);
        cs_end();
        check(we_cnt == w0 && mem[8'h10] == 8'hAA, "R12 no write", we_cnt - w0, 0);

        // R9 aborted partial byte, then fresh command
        wr_burst(8'h40, 8'h3E, 8'h00, 1);
        w0 = we_cnt;
        cs_begin(); send(8'h02); send(8'h40); xbyte(8'hC1, 4, r); cs_end();
        check(we_cnt == w0 && mem[8'h40] == 8'h3E, "R9 partial byte no write", mem[8'h40], 8'h3E);
        cs_begin(); send(8'h03); send(8'h40); recv_expect(8'h3E, "R9 fresh command"); cs_end();

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0 && got_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule